// File: doc/BRIEF.md
# Dual-Channel Pulse-Width Modulator with Clock Pass-Through

This block is a register-mapped pulse-width modulator with two output channels. A 32-bit write/read bus reaches one shared control word and one timing word per channel. Each channel divides the module clock through a selectable prescaler. The divided tick advances a 16-bit counter, and the counter sets the output level.

Each channel has its own prescaler code, output polarity, enable, clock-gate bit and clock pass-through bit. When the pass-through bit is set, the module clock goes straight to the pin and every other setting of that channel is ignored. A write to a timing word is held in a shadow copy. The copy moves into the running counter only at the end of a period, and a per-channel ready flag stays low while such an update is waiting.

Top module: `pwm_dual_ctrl`

## Requirements
- R1: After reset the control word reads 0x3000_0000 (both ready flags set, every field zero) and both outputs sit at the inactive level of a zero polarity bit, which is 1.
- R2: The control word is at byte offset 0x0, and the timing word of channel n is at 0x4 + 4*n. The control field of channel n starts at bit 15*n. Within that field, bits 3:0 are the prescaler code, bit 4 is enable, bit 5 is the active level, bit 6 is the clock gate, bit 7 is mode, bit 8 is pulse and bit 9 is pass-through. All field bits read back as written and every other control bit reads 0, except the ready flags. A timing word reads back exactly as written.
- R3: A channel runs only when both its gate bit and its enable bit are 1. Otherwise, with pass-through clear, its output holds the inactive level, which is the inverse of the active-level bit.
- R4: Timing word bits 31:16 hold P, one less than the period length in ticks, and bits 15:0 hold D. A running channel counts 0..P and then wraps. The output is at the active level (bit 5 of the field) while the count is below D and at the inverse level for the rest of the period.
- R5: If D >= P+1, the output stays at the active level for the whole period. If D = 0, it stays at the inactive level.
- R6: The tick rate is the module clock divided by a value chosen by the prescaler code. The values are: 0xF gives 1; 0..4 give 120, 180, 240, 360 and 480; 8..12 give 12000, 24000, 36000, 48000 and 72000; the reserved codes 5, 6, 7, 13 and 14 give 1. The divider and the counter restart from zero when a channel starts running.
- R7: A running channel takes a newly written timing word only at the end of a period, and the count starts again from 0 with the new values. A channel that is not running takes the new value one cycle after the write.
- R8: The ready flag of channel n is control bit 28+n. It reads 0 from the cycle after a write to that channel's timing word until the new value is taken, and 1 at all other times.
- R9: While a channel's pass-through bit is 1, its output equals the module clock, whatever its prescaler, timing word, polarity, gate and enable hold. Clearing the bit gives the pin back to the counter logic at once.
- R10: The two channels are independent: the settings and writes of one never change the output of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock; also the pass-through source |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr_i | input | 4 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| pwm_o | output | 2 | Channel outputs, bit n for channel n |

## Verification
The bench writes a new timing word in the middle of a period and follows the ready flag. A design that loaded the value at once would show a short, broken period; one that never cleared its pending state would leave the flag low. It covers duty of zero, duty exactly one period long and duty beyond the period, each of which exposes an off-by-one in the compare as a one-cycle glitch. It runs a reserved prescaler code and the 120 divider, where a wrong table or a mis-restarted divider moves the edges. It also turns on pass-through with enable both clear and set, and checks the pin in both clock phases, so a design that still lets enable or the counter through fails in one phase.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;
  localparam int FIELD_STRIDE = 15;
  localparam int PRESC_W      = 4;
  localparam int BIT_EN       = 4;
  localparam int BIT_LVL      = 5;
  localparam int BIT_GATE     = 6;
  localparam int BIT_BYP      = 9;
  localparam int FIELD_W      = 10;
  localparam int READY_BASE   = 28;
  localparam int DIV_W        = 17;

  typedef logic [PRESC_W-1:0] presc_code_t;

  // prescaler code -> divide ratio; unlisted codes run undivided
  function automatic logic [DIV_W-1:0] div_of(presc_code_t code);
    logic [DIV_W-1:0] d;
    case (code)
      4'h0:    d = DIV_W'(120);
      4'h1:    d = DIV_W'(180);
      4'h2:    d = DIV_W'(240);
      4'h3:    d = DIV_W'(360);
      4'h4:    d = DIV_W'(480);
      4'h8:    d = DIV_W'(12000);
      4'h9:    d = DIV_W'(24000);
      4'hA:    d = DIV_W'(36000);
      4'hB:    d = DIV_W'(48000);
      4'hC:    d = DIV_W'(72000);
      default: d = DIV_W'(1);
    endcase
    return d;
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_dual_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  input  logic [NUM_CH-1:0]             ready_i,
  output presc_code_t [NUM_CH-1:0]      presc_o,
  output logic [NUM_CH-1:0]             en_o,
  output logic [NUM_CH-1:0]             lvl_o,
  output logic [NUM_CH-1:0]             gate_o,
  output logic [NUM_CH-1:0]             byp_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  prd_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  dty_o,
  output logic [NUM_CH-1:0]             upd_o
);
  function automatic logic [DATA_W-1:0] ctrl_mask();
    logic [DATA_W-1:0] m = '0;
    for (int c = 0; c < NUM_CH; c++) m[c*FIELD_STRIDE +: FIELD_W] = '1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] CtrlMask = ctrl_mask();

  logic [DATA_W-1:0]             ctrl_q;
  logic [NUM_CH-1:0][DATA_W-1:0] tim_q;
  logic                          ctrl_sel;

  assign ctrl_sel = (addr_i == '0);

  always_comb begin
    for (int c = 0; c < NUM_CH; c++)
      upd_o[c] = we_i && (addr_i == ADDR_W'(4 + 4*c));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      tim_q  <= '0;
    end else begin
      if (we_i && ctrl_sel) ctrl_q <= wdata_i & CtrlMask;
      for (int c = 0; c < NUM_CH; c++)
        if (upd_o[c]) tim_q[c] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (ctrl_sel) begin
      rdata_o = ctrl_q;
      for (int c = 0; c < NUM_CH; c++) rdata_o[READY_BASE + c] = ready_i[c];
    end
    for (int c = 0; c < NUM_CH; c++)
      if (addr_i == ADDR_W'(4 + 4*c)) rdata_o = tim_q[c];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_fld
    localparam int Base = g * FIELD_STRIDE;
    assign presc_o[g] = ctrl_q[Base +: PRESC_W];
    assign en_o[g]    = ctrl_q[Base + BIT_EN];
    assign lvl_o[g]   = ctrl_q[Base + BIT_LVL];
    assign gate_o[g]  = ctrl_q[Base + BIT_GATE];
    assign byp_o[g]   = ctrl_q[Base + BIT_BYP];
    assign prd_o[g]   = tim_q[g][CNT_W +: CNT_W];
    assign dty_o[g]   = tim_q[g][0 +: CNT_W];
  end
endmodule

// File: rtl/pwm_presc.sv
module pwm_presc
  import pwm_dual_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        run_i,
  input  presc_code_t code_i,
  output logic        tick_o
);
  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] pcnt_q;

  assign div    = div_of(code_i);
  assign tick_o = run_i && (pcnt_q == div - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pcnt_q <= '0;
    else if (!run_i) pcnt_q <= '0;
    else if (tick_o) pcnt_q <= '0;
    else             pcnt_q <= pcnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_dual_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  presc_code_t      presc_i,
  input  logic             en_i,
  input  logic             lvl_i,
  input  logic             gate_i,
  input  logic             byp_i,
  input  logic             upd_i,
  input  logic [CNT_W-1:0] prd_i,
  input  logic [CNT_W-1:0] dty_i,
  output logic             wave_o,
  output logic             ready_o,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] prd_cur_o,
  output logic [CNT_W-1:0] dty_cur_o
);
  logic             run, tick, wrap, load;
  logic             pend_q;
  logic [CNT_W-1:0] cnt_q, prd_cur_q, dty_cur_q;

  assign run = gate_i && en_i && !byp_i;

  pwm_presc u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .code_i (presc_i),
    .tick_o (tick)
  );

  assign wrap = tick && (cnt_q == prd_cur_q);
  // idle channel follows the shadow; running one only at wrap
  assign load = !run || (wrap && pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      prd_cur_q <= '0;
      dty_cur_q <= '0;
      pend_q    <= 1'b0;
    end else begin
      if (!run)      cnt_q <= '0;
      else if (tick) cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
      if (load) begin
        prd_cur_q <= prd_i;
        dty_cur_q <= dty_i;
      end
      if (upd_i)     pend_q <= 1'b1;
      else if (load) pend_q <= 1'b0;
    end
  end

  assign wave_o    = (run && (cnt_q < dty_cur_q)) ? lvl_i : !lvl_i;
  assign ready_o   = !pend_q;
  assign run_o     = run;
  assign cnt_o     = cnt_q;
  assign prd_cur_o = prd_cur_q;
  assign dty_cur_o = dty_cur_q;
endmodule

// File: rtl/pwm_dual_ctrl.sv
module pwm_dual_ctrl
  import pwm_dual_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  presc_code_t [NUM_CH-1:0]     presc_w;
  logic [NUM_CH-1:0]            en_w, lvl_w, gate_w, byp_w, upd_w;
  logic [NUM_CH-1:0]            ready_w, run_w, wave_w;
  logic [NUM_CH-1:0][CNT_W-1:0] prd_w, dty_w, cnt_w, prd_cur_w, dty_cur_w;

  pwm_regs #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .ready_i (ready_w),
    .presc_o (presc_w),
    .en_o    (en_w),
    .lvl_o   (lvl_w),
    .gate_o  (gate_w),
    .byp_o   (byp_w),
    .prd_o   (prd_w),
    .dty_o   (dty_w),
    .upd_o   (upd_w)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .presc_i   (presc_w[g]),
      .en_i      (en_w[g]),
      .lvl_i     (lvl_w[g]),
      .gate_i    (gate_w[g]),
      .byp_i     (byp_w[g]),
      .upd_i     (upd_w[g]),
      .prd_i     (prd_w[g]),
      .dty_i     (dty_w[g]),
      .wave_o    (wave_w[g]),
      .ready_o   (ready_w[g]),
      .run_o     (run_w[g]),
      .cnt_o     (cnt_w[g]),
      .prd_cur_o (prd_cur_w[g]),
      .dty_cur_o (dty_cur_w[g])
    );
    // pass-through overrides every other channel setting
    assign pwm_o[g] = byp_w[g] ? clk_i : wave_w[g];
  end
endmodule

// File: rtl/pwm_dual_ctrl_chk.sv
module pwm_dual_ctrl_chk #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         bus_we_i,
  input logic [ADDR_W-1:0]            bus_addr_i,
  input logic [NUM_CH-1:0]            pwm_o,
  input logic [NUM_CH-1:0]            en_w,
  input logic [NUM_CH-1:0]            lvl_w,
  input logic [NUM_CH-1:0]            gate_w,
  input logic [NUM_CH-1:0]            byp_w,
  input logic [NUM_CH-1:0]            run_w,
  input logic [NUM_CH-1:0]            ready_w,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_w,
  input logic [NUM_CH-1:0][CNT_W-1:0] prd_cur_w,
  input logic [NUM_CH-1:0][CNT_W-1:0] dty_cur_w
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    assert_idle_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!byp_w[g] && !(gate_w[g] && en_w[g])) |-> (pwm_o[g] == !lvl_w[g]));

    assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_w[g] |-> (cnt_w[g] <= prd_cur_w[g]));

    assert_full_duty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_w[g] && (dty_cur_w[g] > prd_cur_w[g])) |-> (pwm_o[g] == lvl_w[g]));

    assert_zero_duty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_w[g] && (dty_cur_w[g] == '0)) |-> (pwm_o[g] == !lvl_w[g]));

    assert_ready_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_we_i && (bus_addr_i == ADDR_W'(4 + 4*g))) |=> !ready_w[g]);

    assert_latch_at_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_w[g] && $rose(ready_w[g])) |-> (cnt_w[g] == '0));
  end
endmodule

bind pwm_dual_ctrl pwm_dual_ctrl_chk #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .pwm_o      (pwm_o),
  .en_w       (en_w),
  .lvl_w      (lvl_w),
  .gate_w     (gate_w),
  .byp_w      (byp_w),
  .run_w      (run_w),
  .ready_w    (ready_w),
  .cnt_w      (cnt_w),
  .prd_cur_w  (prd_cur_w),
  .dty_cur_w  (dty_cur_w)
);

// File: tb/test_pwm_dual_ctrl.sv
`timescale 1ns/1ps
module test_pwm_dual_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  pwm;

  int n_vec  = 0;
  int n_fail = 0;

  typedef struct {
    int          kind;   // 0 output, 1 read data, 2 pass-through both phases
    int          req;
    logic [31:0] exp;
    logic [31:0] mask;
    logic [1:0]  hi;
  } item_t;

  item_t sb_q[$];

  always #5 clk = ~clk;

  pwm_dual_ctrl i_pwm_dual_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .pwm_o       (pwm)
  );

  // monitor: pops one item per cycle in the low clock phase
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_vec++;
        case (it.kind)
          0: if (pwm !== it.exp[1:0]) begin
               n_fail++;
               $display("FAIL R%0d: pwm_o=%b expected %b", it.req, pwm, it.exp[1:0]);
             end
          1: if ((rdata & it.mask) !== (it.exp & it.mask)) begin
               n_fail++;
               $display("FAIL R%0d: rdata=%h expected %h (mask %h)", it.req,
                        rdata & it.mask, it.exp & it.mask, it.mask);
             end
          default: begin
            if (pwm !== it.exp[1:0]) begin
              n_fail++;
              $display("FAIL R%0d: low phase pwm_o=%b expected %b", it.req, pwm, it.exp[1:0]);
            end
            @(posedge clk);
            #0.5;
            if (pwm !== it.hi) begin
              n_fail++;
              $display("FAIL R%0d: high phase pwm_o=%b expected %b", it.req, pwm, it.hi);
            end
          end
        endcase
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk);
    #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    we = 1'b0;
  endtask

  task automatic push_pwm(input int req, input logic [1:0] e);
    item_t it;
    it.kind = 0; it.req = req; it.exp = {30'd0, e}; it.mask = '1; it.hi = '0;
    sb_q.push_back(it);
    step();
  endtask

  task automatic push_rd(input int req, input logic [3:0] a, input logic [31:0] e,
                         input logic [31:0] m);
    item_t it;
    addr = a;
    it.kind = 1; it.req = req; it.exp = e; it.mask = m; it.hi = '0;
    sb_q.push_back(it);
    step();
  endtask

  task automatic push_byp(input int req, input logic [1:0] lo, input logic [1:0] hi);
    item_t it;
    it.kind = 2; it.req = req; it.exp = {30'd0, lo}; it.mask = '1; it.hi = hi;
    sb_q.push_back(it);
    step();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    bit got;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    // R1: reset state
    push_rd(1, 4'h0, 32'h3000_0000, 32'hFFFF_FFFF);
    push_pwm(1, 2'b11);

    // R2: timing word and control field read-back
    wr(4'h8, 32'hABCD_1234);
    push_rd(2, 4'h8, 32'hABCD_1234, 32'hFFFF_FFFF);
    wr(4'h0, 32'hFFFF_FFFF);
    push_rd(2, 4'h0, 32'h31FF_83FF, 32'hFFFF_FFFF);
    push_byp(9, 2'b00, 2'b11);   // R9 with every field set
    wr(4'h0, 32'h0);
    push_pwm(2, 2'b11);

    // R4 / R6 (code 0xF): P=4, D=2, active high
    wr(4'h4, 32'h0004_0002);
    wr(4'h0, 32'h0000_007F);
    for (int k = 0; k < 15; k++) push_pwm(4, {1'b1, (k % 5) < 2});

    // R8 / R7: update while running
    wr(4'h4, 32'h0002_0001);
    push_rd(8, 4'h0, 32'h0, 32'h1000_0000);
    got = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (rdata[28]) begin got = 1'b1; break; end
      step();
    end
    n_vec++;
    if (!got) begin
      n_fail++;
      $display("FAIL R8: ready flag=0 after wait, expected 1");
    end
    for (int k = 0; k < 9; k++) push_pwm(7, {1'b1, (k % 3) < 1});

    // R3: gate without enable, enable without gate
    wr(4'h0, 32'h0000_006F);
    push_pwm(3, 2'b10);
    wr(4'h0, 32'h0000_003F);
    push_pwm(3, 2'b10);

    // R4: inverted polarity
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h0004_0002);
    wr(4'h0, 32'h0000_005F);
    for (int k = 0; k < 10; k++) push_pwm(4, {1'b1, !((k % 5) < 2)});

    // R5: duty beyond, equal to, and zero
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h0003_0009);
    wr(4'h0, 32'h0000_007F);
    for (int k = 0; k < 8; k++) push_pwm(5, 2'b11);
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h0003_0004);
    wr(4'h0, 32'h0000_007F);
    for (int k = 0; k < 8; k++) push_pwm(5, 2'b11);
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h0003_0000);
    wr(4'h0, 32'h0000_007F);
    for (int k = 0; k < 8; k++) push_pwm(5, 2'b10);

    // R6: reserved code 5 runs undivided
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h0002_0001);
    wr(4'h0, 32'h0000_0075);
    for (int k = 0; k < 9; k++) push_pwm(6, {1'b1, (k % 3) < 1});

    // R6: code 0 divides by 120
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h0001_0001);
    wr(4'h0, 32'h0000_0070);
    for (int k = 0; k < 480; k++) push_pwm(6, {1'b1, ((k / 120) % 2) == 0});

    // R9: pass-through with enable clear, then set
    wr(4'h0, 32'h0);
    wr(4'h0, 32'h0000_0200);
    for (int k = 0; k < 3; k++) push_byp(9, 2'b10, 2'b11);
    wr(4'h0, 32'h0000_027F);
    for (int k = 0; k < 3; k++) push_byp(9, 2'b10, 2'b11);
    wr(4'h0, 32'h0);
    push_pwm(9, 2'b11);

    // R10: channel 1 alone, field at bit 15
    wr(4'h8, 32'h0002_0001);
    wr(4'h0, 32'h003F_8000);
    for (int k = 0; k < 9; k++) push_pwm(10, {(k % 3) < 1, 1'b1});
    wr(4'h8, 32'h0001_0001);
    push_rd(10, 4'h0, 32'h1000_0000, 32'h3000_0000);   // R8 on channel 1 only

    wait (sb_q.size() == 0);
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule